// File: doc/BRIEF.md
# Processor trap entry unit

This unit sits beside the execution pipeline of a 32-bit RISC core with overlapping register windows. It tracks one pending trap type. That type is loaded from synchronous trap requests raised by the pipeline, or from a 15-level external interrupt vector. At an instruction boundary the unit takes the pending trap in one clock cycle. In that cycle it disables further traps, rotates the window pointer, and saves and sets the supervisor bits. It merges the trap type into the trap base register and redirects fetch to the resulting vector. It also emits a two-register write of the return PC pair into the new window, and an acknowledge for external interrupts.

If a trap is taken while traps are already disabled, no state changes. The unit instead enters a sticky error mode. The one exception is software trap 0x80 when the halt option is enabled: that case raises a sticky shutdown request. After either outcome the unit stays frozen until reset.

Top module: `trap_entry_unit`

## Requirements
- R1: The external level is the index of the highest set bit among `irq_lines[15:1]`. Bit 0 never causes a request. The resulting trap type is 0x10 OR the level, so its upper nibble is 1.
- R2: An external level may load or replace `pending_tt` only when `pending_tt` is 0 or has upper nibble 1. A pending synchronous trap (any other nonzero value) is never overwritten, neither by interrupts nor by another `sync_valid`.
- R3: When `irq_lines[15:1]` is all zero and an external type is pending, `pending_tt` returns to 0 on the next edge and `int_req` (high exactly while an external type is pending) falls.
- R4: `int_notify` pulses for one cycle after an edge that gives `pending_tt` a new external type different from its previous value. It stays low while that type is unchanged.
- R5: A trap taken at an edge with `boundary`=1, a nonzero pending type and `et`=1 clears `et`, sets `cwp` to (cwp-1) mod 8 (so 0 becomes 7), copies `s` into `ps`, and sets `s` to 1.
- R6: In the cycle after a trap, `win_we` is 1, `win_sel` equals the new `cwp`, `win_l1_data` holds `cur_pc`, and `win_l2_data` holds `cur_npc`.
- R7: After a trap, `tbr[31:12]` is unchanged, `tbr[11:4]` holds the trap type, and `tbr[3:0]` is 0. `fetch_redirect` pulses with `fetch_pc` = `tbr` and `fetch_npc` = `tbr`+4.
- R8: A trap clears `pending_tt` to 0. `ack_valid` pulses with `ack_tt` equal to the trap type only when that type has upper nibble 1.
- R9: A trap with `et`=0 changes no processor state and issues no redirect. It sets a sticky `error_mode`, unless the type is 0x80 and `halt_en`=1, in which case it sets a sticky `shutdown_req` instead.
- R10: After reset: `et`=1, `s`=1, `ps`=0, `cwp`=0, `tbr`={RST_TBA,12'h000}, `pending_tt`=0, and all pulse and status outputs are 0.
- R11: When `sync_valid` and interrupt lines are both active in the same cycle and no synchronous trap is pending, the synchronous type is loaded, replacing any pending external type.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | External interrupt levels, bit 0 unused |
| sync_valid | input | 1 | Synchronous trap request |
| sync_tt | input | 8 | Synchronous trap type (not 0x10-0x1F) |
| boundary | input | 1 | Instruction boundary, trap may be taken |
| halt_en | input | 1 | Enables the halt outcome for type 0x80 |
| cur_pc | input | 32 | PC at the boundary |
| cur_npc | input | 32 | Next PC at the boundary |
| pending_tt | output | 8 | Pending trap type, 0 means none |
| int_req | output | 1 | External interrupt pending toward the core |
| int_notify | output | 1 | Pulse: newly selected external type |
| et | output | 1 | Trap enable bit |
| s | output | 1 | Supervisor bit |
| ps | output | 1 | Previous supervisor bit |
| cwp | output | 3 | Current window pointer |
| tbr | output | 32 | Trap base register |
| fetch_redirect | output | 1 | Pulse: fetch restarts at fetch_pc |
| fetch_pc | output | 32 | Trap vector |
| fetch_npc | output | 32 | Trap vector plus 4 |
| win_we | output | 1 | Pulse: write locals 1 and 2 of a window |
| win_sel | output | 3 | Window written |
| win_l1_data | output | 32 | Saved PC |
| win_l2_data | output | 32 | Saved next PC |
| ack_valid | output | 1 | Pulse: external interrupt acknowledged |
| ack_tt | output | 8 | Acknowledged trap type |
| error_mode | output | 1 | Sticky error state |
| shutdown_req | output | 1 | Sticky clean-halt request |

## Verification
Several interrupt vectors are applied to the selection logic. Bit 0 alone shows that level 0 is ignored. Multi-bit vectors with widely spaced bits separate highest-bit selection from lowest-bit selection. A falling level shows that an external type may be replaced by a lower one. Synchronous requests arriving with and against interrupts, including a second synchronous request, show which source may overwrite which. Traps are taken from window 0 to expose the wraparound, with both an external and a synchronous type so that only one of them acknowledges. Back-to-back traps then exercise the disabled-trap outcomes: an interrupt, type 0x80 with the halt option, and type 0x80 without it.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int TT_W    = 8;
    localparam int TBA_W   = 20;
    localparam int NWIN    = 8;
    localparam int CWP_W   = $clog2(NWIN);
    localparam int IRQ_W   = 16;
    localparam int LVL_W   = $clog2(IRQ_W);
    localparam int XLEN    = 32;
    localparam logic [TT_W-1:0] EXT_BASE = TT_W'(8'h10);
    localparam logic [TT_W-1:0] HALT_TT  = TT_W'(8'h80);

    typedef struct packed {
        logic [TT_W-1:0]  pend;
        logic             et;
        logic             s;
        logic             ps;
        logic [CWP_W-1:0] cwp;
        logic [TBA_W-1:0] tba;
        logic [TT_W-1:0]  tt;
        logic             redirect;
        logic [XLEN-1:0]  fpc;
        logic [XLEN-1:0]  fnpc;
        logic             we;
        logic [XLEN-1:0]  l1;
        logic [XLEN-1:0]  l2;
        logic             ack;
        logic [TT_W-1:0]  ack_tt;
        logic             notify;
        logic             err;
        logic             halt;
    } trap_state_t;

    function automatic logic is_ext(input logic [TT_W-1:0] t);
        return t[TT_W-1:4] == EXT_BASE[TT_W-1:4];
    endfunction
endpackage

// File: rtl/trap_irq_select.sv
module trap_irq_select #(
    parameter int LINES = 16,
    localparam int LW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] lines,
    output logic             any,
    output logic [LW-1:0]    level
);
    always_comb begin
        any   = 1'b0;
        level = '0;
        for (int i = 1; i < LINES; i++) begin
            if (lines[i]) begin
                any   = 1'b1;
                level = LW'(i);
            end
        end
    end
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
    parameter int TBA_W = 20,
    parameter int TT_W  = 8,
    localparam int XW   = TBA_W + TT_W + 4
) (
    input  logic [TBA_W-1:0] tba,
    input  logic [TT_W-1:0]  tt,
    output logic [XW-1:0]    vec,
    output logic [XW-1:0]    vec_next
);
    assign vec      = {tba, tt, 4'b0000};
    assign vec_next = vec + XW'(4);
endmodule

// File: rtl/trap_cwp_step.sv
module trap_cwp_step #(
    parameter int NWIN = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic [CW-1:0] cwp,
    output logic [CW-1:0] cwp_dec
);
    generate
        if ((1 << CW) == NWIN) begin : g_pow2
            assign cwp_dec = cwp - CW'(1);
        end else begin : g_mod
            assign cwp_dec = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);
        end
    endgenerate
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter logic [TBA_W-1:0] RST_TBA = 20'h40000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQ_W-1:0]    irq_lines,
    input  logic                sync_valid,
    input  logic [TT_W-1:0]     sync_tt,
    input  logic                boundary,
    input  logic                halt_en,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [XLEN-1:0]     cur_npc,
    output logic [TT_W-1:0]     pending_tt,
    output logic                int_req,
    output logic                int_notify,
    output logic                et,
    output logic                s,
    output logic                ps,
    output logic [CWP_W-1:0]    cwp,
    output logic [XLEN-1:0]     tbr,
    output logic                fetch_redirect,
    output logic [XLEN-1:0]     fetch_pc,
    output logic [XLEN-1:0]     fetch_npc,
    output logic                win_we,
    output logic [CWP_W-1:0]    win_sel,
    output logic [XLEN-1:0]     win_l1_data,
    output logic [XLEN-1:0]     win_l2_data,
    output logic                ack_valid,
    output logic [TT_W-1:0]     ack_tt,
    output logic                error_mode,
    output logic                shutdown_req
);
    trap_state_t st_d, st_q;

    logic             irq_any;
    logic [LVL_W-1:0] irq_lvl;
    logic [XLEN-1:0]  vec, vec_next;
    logic [CWP_W-1:0] cwp_dec;
    logic             ext_pend, sync_pend;
    logic [TT_W-1:0]  irq_tt;

    trap_irq_select #(.LINES(IRQ_W)) u_sel (
        .lines (irq_lines),
        .any   (irq_any),
        .level (irq_lvl)
    );

    trap_vector_calc #(.TBA_W(TBA_W), .TT_W(TT_W)) u_vec (
        .tba      (st_q.tba),
        .tt       (st_q.pend),
        .vec      (vec),
        .vec_next (vec_next)
    );

    trap_cwp_step #(.NWIN(NWIN)) u_cwp (
        .cwp     (st_q.cwp),
        .cwp_dec (cwp_dec)
    );

    assign ext_pend  = is_ext(st_q.pend);
    assign sync_pend = (st_q.pend != '0) && !ext_pend;
    assign irq_tt    = EXT_BASE | TT_W'(irq_lvl);

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.we       = 1'b0;
        st_d.ack      = 1'b0;
        st_d.notify   = 1'b0;
        if (st_q.err || st_q.halt) begin
            st_d.pend = st_q.pend;
        end else if (boundary && st_q.pend != '0) begin
            st_d.pend = '0;
            if (!st_q.et) begin
                if (st_q.pend == HALT_TT && halt_en) st_d.halt = 1'b1;
                else                                 st_d.err  = 1'b1;
            end else begin
                st_d.et       = 1'b0;
                st_d.cwp      = cwp_dec;
                st_d.ps       = st_q.s;
                st_d.s        = 1'b1;
                st_d.tt       = st_q.pend;
                st_d.redirect = 1'b1;
                st_d.fpc      = vec;
                st_d.fnpc     = vec_next;
                st_d.we       = 1'b1;
                st_d.l1       = cur_pc;
                st_d.l2       = cur_npc;
                st_d.ack      = ext_pend;
                st_d.ack_tt   = st_q.pend;
            end
        end else begin
            if (sync_valid && !sync_pend)     st_d.pend = sync_tt;
            else if (irq_any && !sync_pend)   st_d.pend = irq_tt;
            else if (!irq_any && ext_pend)    st_d.pend = '0;
            st_d.notify = is_ext(st_d.pend) && (st_d.pend != st_q.pend);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.et  <= 1'b1;
            st_q.s   <= 1'b1;
            st_q.tba <= RST_TBA;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_tt     = st_q.pend;
    assign int_req        = ext_pend;
    assign int_notify     = st_q.notify;
    assign et             = st_q.et;
    assign s              = st_q.s;
    assign ps             = st_q.ps;
    assign cwp            = st_q.cwp;
    assign tbr            = {st_q.tba, st_q.tt, 4'b0000};
    assign fetch_redirect = st_q.redirect;
    assign fetch_pc       = st_q.fpc;
    assign fetch_npc      = st_q.fnpc;
    assign win_we         = st_q.we;
    assign win_sel        = st_q.cwp;
    assign win_l1_data    = st_q.l1;
    assign win_l2_data    = st_q.l2;
    assign ack_valid      = st_q.ack;
    assign ack_tt         = st_q.ack_tt;
    assign error_mode     = st_q.err;
    assign shutdown_req   = st_q.halt;
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker
    import trap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [IRQ_W-1:0]   irq_lines,
    input logic               boundary,
    input logic [TT_W-1:0]    pending_tt,
    input logic               int_req,
    input logic               int_notify,
    input logic               et,
    input logic [CWP_W-1:0]   cwp,
    input logic [XLEN-1:0]    tbr,
    input logic               fetch_redirect,
    input logic [XLEN-1:0]    fetch_pc,
    input logic [XLEN-1:0]    fetch_npc,
    input logic               win_we,
    input logic [CWP_W-1:0]   win_sel,
    input logic               ack_valid,
    input logic [TT_W-1:0]    ack_tt,
    input logic               error_mode,
    input logic               shutdown_req
);
    logic sync_held;
    assign sync_held = (pending_tt != '0) && !is_ext(pending_tt);

    assert_sync_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_held |=> ($stable(pending_tt) || fetch_redirect || error_mode || shutdown_req));

    assert_withdraw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && irq_lines[IRQ_W-1:1] == '0 && !boundary) |=> !int_req);

    assert_notify_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_notify) |-> (int_req && pending_tt != $past(pending_tt)));

    assert_et_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> !et);

    assert_cwp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_redirect) |-> (cwp == (($past(cwp) == '0) ? CWP_W'(NWIN - 1) : $past(cwp) - CWP_W'(1))));

    assert_win_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> (win_we && win_sel == cwp));

    assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> (fetch_pc == tbr && fetch_npc == tbr + 32'd4 && tbr[3:0] == 4'd0));

    assert_ack_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (is_ext(ack_tt) && fetch_redirect && pending_tt == '0));

    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error_mode |=> (error_mode && !fetch_redirect));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> (shutdown_req && !error_mode));
endmodule

bind trap_entry_unit trap_entry_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_lines      (irq_lines),
    .boundary       (boundary),
    .pending_tt     (pending_tt),
    .int_req        (int_req),
    .int_notify     (int_notify),
    .et             (et),
    .cwp            (cwp),
    .tbr            (tbr),
    .fetch_redirect (fetch_redirect),
    .fetch_pc       (fetch_pc),
    .fetch_npc      (fetch_npc),
    .win_we         (win_we),
    .win_sel        (win_sel),
    .ack_valid      (ack_valid),
    .ack_tt         (ack_tt),
    .error_mode     (error_mode),
    .shutdown_req   (shutdown_req)
);

// File: tb/sim_trap_entry_unit.sv
`timescale 1ns/1ps
module sim_trap_entry_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_lines;
    logic        sync_valid;
    logic [7:0]  sync_tt;
    logic        boundary;
    logic        halt_en;
    logic [31:0] cur_pc, cur_npc;
    logic [7:0]  pending_tt, ack_tt;
    logic        int_req, int_notify, et, s, ps;
    logic [2:0]  cwp, win_sel;
    logic [31:0] tbr, fetch_pc, fetch_npc, win_l1_data, win_l2_data;
    logic        fetch_redirect, win_we, ack_valid, error_mode, shutdown_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    trap_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .sync_valid(sync_valid),
        .sync_tt(sync_tt), .boundary(boundary), .halt_en(halt_en),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .pending_tt(pending_tt),
        .int_req(int_req), .int_notify(int_notify), .et(et), .s(s), .ps(ps),
        .cwp(cwp), .tbr(tbr), .fetch_redirect(fetch_redirect),
        .fetch_pc(fetch_pc), .fetch_npc(fetch_npc), .win_we(win_we),
        .win_sel(win_sel), .win_l1_data(win_l1_data), .win_l2_data(win_l2_data),
        .ack_valid(ack_valid), .ack_tt(ack_tt), .error_mode(error_mode),
        .shutdown_req(shutdown_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_lines = '0; sync_valid = 1'b0; sync_tt = '0;
        boundary = 1'b0; halt_en = 1'b0; cur_pc = '0; cur_npc = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic take();
        boundary = 1'b1;
        step();
        boundary = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 et", et, 1);
        chk("R10 s", s, 1);
        chk("R10 ps", ps, 0);
        chk("R10 cwp", cwp, 0);
        chk("R10 tbr", tbr, 32'h4000_0000);
        chk("R10 pending", pending_tt, 0);
        chk("R10 pulses", {fetch_redirect, win_we, ack_valid, int_notify, int_req, error_mode, shutdown_req}, 0);
    endtask

    task automatic t_priority();
        do_reset();
        irq_lines = 16'h0001; step();
        chk("R1 bit0 ignored", pending_tt, 0);
        irq_lines = 16'h0028; step();
        chk("R1 highest of 5,3", pending_tt, 8'h15);
        chk("R4 notify new", int_notify, 1);
        chk("R3 int_req level", int_req, 1);
        step();
        chk("R4 no notify same", int_notify, 0);
        irq_lines = 16'h8028; step();
        chk("R1 level 15", pending_tt, 8'h1F);
        chk("R4 notify change", int_notify, 1);
        irq_lines = 16'h0004; step();
        chk("R2 ext replaces ext", pending_tt, 8'h12);
        irq_lines = 16'h0000; step();
        chk("R3 pending cleared", pending_tt, 0);
        chk("R3 int_req withdrawn", int_req, 0);
    endtask

    task automatic t_sync_rules();
        do_reset();
        irq_lines = 16'h0010; step();
        chk("R1 level 4", pending_tt, 8'h14);
        irq_lines = 16'h8000; sync_valid = 1'b1; sync_tt = 8'h05; step();
        chk("R11 sync wins", pending_tt, 8'h05);
        chk("R11 int_req low", int_req, 0);
        sync_tt = 8'h07; step();
        chk("R2 sync not replaced by sync", pending_tt, 8'h05);
        sync_valid = 1'b0; irq_lines = 16'hFFFE; step();
        chk("R2 sync not replaced by irq", pending_tt, 8'h05);
        irq_lines = 16'h0000; step();
        chk("R2 sync kept on irq drop", pending_tt, 8'h05);
        cur_pc = 32'h0000_1000; cur_npc = 32'h0000_1004;
        take();
        chk("R7 redirect", fetch_redirect, 1);
        chk("R7 tbr", tbr, 32'h4000_0050);
        chk("R7 fetch_pc", fetch_pc, 32'h4000_0050);
        chk("R7 fetch_npc", fetch_npc, 32'h4000_0054);
        chk("R5 et", et, 0);
        chk("R5 cwp wrap", cwp, 7);
        chk("R5 s", s, 1);
        chk("R5 ps", ps, 1);
        chk("R6 we", win_we, 1);
        chk("R6 sel", win_sel, 7);
        chk("R6 l1", win_l1_data, 32'h0000_1000);
        chk("R6 l2", win_l2_data, 32'h0000_1004);
        chk("R8 no ack for sync", ack_valid, 0);
        chk("R8 pending none", pending_tt, 0);
        step();
        chk("R7 redirect one cycle", fetch_redirect, 0);
    endtask

    task automatic t_ext_take();
        do_reset();
        irq_lines = 16'h0800; step();
        cur_pc = 32'h0000_2000; cur_npc = 32'h0000_2004;
        take();
        chk("R8 ack", ack_valid, 1);
        chk("R8 ack_tt", ack_tt, 8'h1B);
        chk("R8 pending none", pending_tt, 0);
        chk("R7 tbr ext", tbr, 32'h4000_01B0);
        chk("R7 npc ext", fetch_npc, 32'h4000_01B4);
        step();
        chk("R8 ack one cycle", ack_valid, 0);
        chk("R1 reloaded", pending_tt, 8'h1B);
        take();
        chk("R9 error", error_mode, 1);
        chk("R9 no redirect", fetch_redirect, 0);
        chk("R9 cwp unchanged", cwp, 7);
        chk("R9 tbr unchanged", tbr, 32'h4000_01B0);
        step();
        chk("R9 error sticky", error_mode, 1);
    endtask

    task automatic t_halt(input logic en);
        do_reset();
        sync_valid = 1'b1; sync_tt = 8'h01; step();
        sync_valid = 1'b0;
        take();
        chk("R5 first trap et", et, 0);
        halt_en = en; sync_valid = 1'b1; sync_tt = 8'h80; step();
        sync_valid = 1'b0;
        take();
        chk("R9 shutdown", shutdown_req, en);
        chk("R9 error", error_mode, !en);
        chk("R9 cwp held", cwp, 7);
        chk("R9 no redirect", fetch_redirect, 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_priority();
        t_sync_rules();
        t_ext_take();
        t_halt(1'b1);
        t_halt(1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule